// File: doc/BRIEF.md
# Exception Stack Frame Builder

This block turns an accepted exception request into a two-longword frame on the supervisor stack. It takes an 8-bit vector number, a 4-bit fault status, the 16-bit status register and a pair of candidate return addresses. It rounds the supervisor stack pointer down to a longword boundary, then writes the return address and a packed format/vector/status longword through a 32-bit write port. That port uses a valid/ready handshake. The frame records how far the stack pointer was moved by the alignment.

When both writes are done, the block does three things. It pulses the vector-table fetch address for one cycle. It publishes the new stack pointer, which is the aligned value minus 8. It keeps an interrupt-inhibit output high until the core reports that the handler's first instruction has retired.

The core raises a request only while `busy` is low. The block ignores requests that arrive while a frame is in progress.

Top module: `exc_frame_builder`

## Requirements
- R1: After reset, `busy`, `mem_wvalid`, `vec_valid` and `irq_inhibit` are low and `ssp_out` is zero.
- R2: A request is taken only while `busy` is low. A `req_valid` that arrives while busy is ignored: it starts no frame and changes neither the frame contents nor the outputs.
- R3: In the cycle after acceptance, `mem_wvalid` is high with address (aligned SSP − 4) and the return address as data. Aligned SSP is `ssp_in` with bits 1:0 cleared. Address and data stay stable until `mem_wready` is seen.
- R4: In the cycle after the first write completes, the second write is presented at aligned SSP − 8. Its data has format in bits 31:28, fault status bits 3:2 in bits 27:26, the vector in bits 25:18, fault status bits 1:0 in bits 17:16 and the status register in bits 15:0.
- R5: The format field equals 4 + `ssp_in[1:0]`, so it is 4, 5, 6 or 7.
- R6: The fault status bits of the frame carry `req_fs` only for vector 2 (access error) and vector 3 (address error). For all other vectors they are zero.
- R7: The return address is `req_next_pc` when `req_use_next` is high or the vector is in 32..47 (trap instructions). Otherwise it is `req_fault_pc`.
- R8: In the cycle after the second write completes, `vec_valid` is high for exactly one cycle, with `vec_addr` = `vbr` + 4 × vector.
- R9: `ssp_out` changes to aligned SSP − 8 in the same cycle that `vec_valid` rises. It holds that value at all other times.
- R10: `busy` is high from the cycle after acceptance through the `vec_valid` cycle, and low in the cycle after that.
- R11: `irq_inhibit` rises in the cycle after acceptance. It falls in the cycle after `handler_retire` is sampled while the block is idle. A `handler_retire` that arrives while busy has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request strobe |
| req_vector | input | 8 | Vector number |
| req_fs | input | 4 | Fault status |
| req_sr | input | 16 | Status register value to store |
| req_use_next | input | 1 | Store next-instruction address instead of faulting one |
| req_fault_pc | input | 32 | Address of the faulting instruction |
| req_next_pc | input | 32 | Address of the following instruction |
| ssp_in | input | 32 | Supervisor stack pointer at exception time |
| vbr | input | 32 | Vector table base |
| handler_retire | input | 1 | Handler's first instruction retired |
| busy | output | 1 | Frame sequence in progress |
| mem_wvalid | output | 1 | Write request valid |
| mem_waddr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data |
| mem_wready | input | 1 | Memory accepts the write |
| vec_valid | output | 1 | One-cycle vector fetch address strobe |
| vec_addr | output | 32 | Vector table entry address |
| ssp_out | output | 32 | Stack pointer after the frame |
| irq_inhibit | output | 1 | Interrupt sampling blocked |

## Verification
Every result is registered, so each is due a fixed number of cycles after the edge that triggers it:
- The first write request is due one cycle after the accepting edge.
- The second write is due one cycle after the edge where the first write meets `mem_wready`.
- The vector strobe and the new stack pointer are due one cycle after the second write is taken, and `busy` falls one cycle after that.
- The inhibit flag drops one cycle after an idle retire.

The bench keeps a reference model that advances on the rising edge from the same inputs the design sees. On every falling edge it compares all outputs against that model, so each result is checked in exactly the cycle it is due. Ready stalls come from a pseudo-random pattern, which stretches the write phases by varying amounts.

// File: rtl/exc_frame_pkg.sv
// Package: shared field widths and sequencer state encoding for the
// exception stack frame builder. Assumes a 32-bit longword frame.
package exc_frame_pkg;
    localparam int unsigned LW_W     = 32;
    localparam int unsigned VEC_W    = 8;
    localparam int unsigned FS_W     = 4;
    localparam int unsigned SR_W     = 16;
    localparam int unsigned FMT_W    = 4;
    localparam int unsigned LW_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH_PC = 2'd1,
        ST_PUSH_FV = 2'd2,
        ST_ISSUE   = 2'd3
    } frame_state_e;
endpackage

// File: rtl/exc_frame_fmt.sv
// Module: exc_frame_fmt
// Purely combinational frame composer. It aligns the stack pointer and
// builds the format/vector/status longword and the return-address longword.
// It also forms the vector table address. Assumes ADDR_W = 32 so that one
// address fills one longword.
module exc_frame_fmt
    import exc_frame_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ACCESS_VEC  = 2,
    parameter int unsigned ADDRESS_VEC = 3,
    parameter int unsigned TRAP_FIRST  = 32,
    parameter int unsigned TRAP_COUNT  = 16
) (
    input  logic [VEC_W-1:0]  vector,
    input  logic [FS_W-1:0]   fs,
    input  logic [SR_W-1:0]   sr,
    input  logic              use_next,
    input  logic [ADDR_W-1:0] fault_pc,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [ADDR_W-1:0] ssp,
    input  logic [ADDR_W-1:0] vbr,
    output logic [LW_W-1:0]   fv_word,
    output logic [LW_W-1:0]   pc_word,
    output logic [ADDR_W-1:0] frame_base,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam int unsigned CMP_W    = VEC_W + 1;
    localparam int unsigned TRAP_END = TRAP_FIRST + TRAP_COUNT;

    logic             is_trap;
    logic             keep_fs;
    logic [FS_W-1:0]  fs_eff;
    logic [FMT_W-1:0] fmt;

    // Classify the vector: trap range and fault-status carrying vectors.
    always_comb begin
        is_trap = ({1'b0, vector} >= CMP_W'(TRAP_FIRST)) &&
                  ({1'b0, vector} <  CMP_W'(TRAP_END));
        keep_fs = (vector == VEC_W'(ACCESS_VEC)) ||
                  (vector == VEC_W'(ADDRESS_VEC));
        fs_eff  = keep_fs ? fs : '0;
    end

    // Format field records the alignment distance: 4 + low two bits.
    always_comb begin
        fmt        = {2'b01, ssp[1:0]};
        frame_base = {ssp[ADDR_W-1:2], 2'b00};
    end

    // Pack the two frame longwords and the vector fetch address.
    always_comb begin
        fv_word  = {fmt, fs_eff[3:2], vector, fs_eff[1:0], sr};
        pc_word  = (use_next || is_trap) ? next_pc : fault_pc;
        vec_addr = vbr + ADDR_W'({vector, 2'b00});
    end
endmodule

// File: rtl/exc_frame_seq.sv
// Module: exc_frame_seq
// Sequencer: it captures a composed frame on acceptance, pushes the two
// longwords through the valid/ready port, pulses the vector address and
// publishes the new stack pointer. It also holds the interrupt-inhibit
// flag. Assumes the composed inputs are valid whenever req_valid is high.
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LW_W-1:0]   fv_word,
    input  logic [LW_W-1:0]   pc_word,
    input  logic [ADDR_W-1:0] frame_base,
    input  logic [ADDR_W-1:0] vec_addr_in,
    input  logic              handler_retire,
    input  logic              mem_wready,
    output logic              busy,
    output logic              mem_wvalid,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [LW_W-1:0]   mem_wdata,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] ssp_out,
    output logic              irq_inhibit
);
    localparam logic [ADDR_W-1:0] PC_OFS = ADDR_W'(LW_BYTES);
    localparam logic [ADDR_W-1:0] FV_OFS = ADDR_W'(2 * LW_BYTES);

    frame_state_e      state_q;
    logic [LW_W-1:0]   fv_q;
    logic [LW_W-1:0]   pc_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] vaddr_q;
    logic [ADDR_W-1:0] ssp_q;
    logic              inh_q;
    logic              accept;

    // Acceptance happens only in the idle state.
    always_comb accept = req_valid && (state_q == ST_IDLE);

    // Frame sequence state, captured frame contents and published SSP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fv_q    <= '0;
            pc_q    <= '0;
            base_q  <= '0;
            vaddr_q <= '0;
            ssp_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    fv_q    <= fv_word;
                    pc_q    <= pc_word;
                    base_q  <= frame_base;
                    vaddr_q <= vec_addr_in;
                    state_q <= ST_PUSH_PC;
                end
                ST_PUSH_PC: if (mem_wready) state_q <= ST_PUSH_FV;
                ST_PUSH_FV: if (mem_wready) begin
                    ssp_q   <= base_q - FV_OFS;
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Inhibit flag: set on acceptance, cleared by an idle retire.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  inh_q <= 1'b0;
        else if (accept)                             inh_q <= 1'b1;
        else if (state_q == ST_IDLE && handler_retire) inh_q <= 1'b0;
    end

    // Write port and status outputs decoded from the sequence state.
    always_comb begin
        mem_wvalid  = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_FV);
        mem_waddr   = (state_q == ST_PUSH_PC) ? base_q - PC_OFS : base_q - FV_OFS;
        mem_wdata   = (state_q == ST_PUSH_PC) ? pc_q : fv_q;
        vec_valid   = (state_q == ST_ISSUE);
        vec_addr    = vaddr_q;
        busy        = (state_q != ST_IDLE);
        ssp_out     = ssp_q;
        irq_inhibit = inh_q;
    end
endmodule

// File: rtl/exc_frame_builder.sv
// Module: exc_frame_builder (top)
// Builds a two-longword exception frame on the supervisor stack and then
// issues the vector fetch address. Assumes requests arrive only while busy
// is low, and that no nested fault occurs while the frame is being written.
module exc_frame_builder #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ACCESS_VEC  = 2,
    parameter int unsigned ADDRESS_VEC = 3,
    parameter int unsigned TRAP_FIRST  = 32,
    parameter int unsigned TRAP_COUNT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_vector,
    input  logic [3:0]        req_fs,
    input  logic [15:0]       req_sr,
    input  logic              req_use_next,
    input  logic [ADDR_W-1:0] req_fault_pc,
    input  logic [ADDR_W-1:0] req_next_pc,
    input  logic [ADDR_W-1:0] ssp_in,
    input  logic [ADDR_W-1:0] vbr,
    input  logic              handler_retire,
    output logic              busy,
    output logic              mem_wvalid,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_wready,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] ssp_out,
    output logic              irq_inhibit
);
    logic [31:0]       fv_word;
    logic [31:0]       pc_word;
    logic [ADDR_W-1:0] frame_base;
    logic [ADDR_W-1:0] vec_addr_c;

    exc_frame_fmt #(
        .ADDR_W(ADDR_W), .ACCESS_VEC(ACCESS_VEC), .ADDRESS_VEC(ADDRESS_VEC),
        .TRAP_FIRST(TRAP_FIRST), .TRAP_COUNT(TRAP_COUNT)
    ) u_fmt (
        .vector(req_vector), .fs(req_fs), .sr(req_sr), .use_next(req_use_next),
        .fault_pc(req_fault_pc), .next_pc(req_next_pc), .ssp(ssp_in), .vbr(vbr),
        .fv_word(fv_word), .pc_word(pc_word), .frame_base(frame_base),
        .vec_addr(vec_addr_c)
    );

    exc_frame_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .fv_word(fv_word), .pc_word(pc_word), .frame_base(frame_base),
        .vec_addr_in(vec_addr_c), .handler_retire(handler_retire),
        .mem_wready(mem_wready), .busy(busy), .mem_wvalid(mem_wvalid),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .vec_valid(vec_valid),
        .vec_addr(vec_addr), .ssp_out(ssp_out), .irq_inhibit(irq_inhibit)
    );
endmodule

// File: rtl/exc_frame_chk.sv
// Module: exc_frame_chk
// Protocol checker bound to exc_frame_builder. It observes ports only.
module exc_frame_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_wvalid,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [31:0]       mem_wdata,
    input logic              mem_wready,
    input logic              vec_valid,
    input logic [ADDR_W-1:0] ssp_out,
    input logic              irq_inhibit,
    input logic              handler_retire
);
    // R3: a stalled write holds its address and data
    assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata));

    // R3: frame writes are longword aligned
    assert_write_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> mem_waddr[1:0] == 2'b00);

    // R8: the vector strobe lasts one cycle
    assert_vec_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R8: the strobe never overlaps a frame write
    assert_vec_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !mem_wvalid);

    // R9: the stack pointer output does not move while idle
    assert_ssp_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(ssp_out));

    // R9: the published stack pointer is longword aligned
    assert_ssp_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ssp_out[1:0] == 2'b00);

    // R10: busy covers writes and the strobe
    assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid || vec_valid) |-> busy);

    // R11: inhibit is held throughout the sequence, and a busy retire does not clear it
    assert_inhibit_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> irq_inhibit);
    assert_retire_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && handler_retire && irq_inhibit |=> irq_inhibit);
endmodule

bind exc_frame_builder exc_frame_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_wvalid(mem_wvalid),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wready(mem_wready),
    .vec_valid(vec_valid), .ssp_out(ssp_out), .irq_inhibit(irq_inhibit),
    .handler_retire(handler_retire)
);

// File: tb/sim_exc_frame_builder.sv
`timescale 1ns/1ps
module sim_exc_frame_builder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic [3:0]  req_fs = '0;
    logic [15:0] req_sr = '0;
    logic        req_use_next = 1'b0;
    logic [31:0] req_fault_pc = '0, req_next_pc = '0, ssp_in = '0, vbr = '0;
    logic        handler_retire = 1'b0;
    logic        mem_wready = 1'b1;
    logic        busy, mem_wvalid, vec_valid, irq_inhibit;
    logic [31:0] mem_waddr, mem_wdata, vec_addr, ssp_out;

    int n_checks = 0;
    int n_err = 0;
    int cycles = 0;
    bit wait_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int          m_phase = 0;
    logic [31:0] m_base = '0, m_pc = '0, m_fv = '0, m_vaddr = '0, m_ssp = '0;
    logic        m_inh = 1'b0;
    logic [31:0] last_pc = '0, last_fv = '0, last_vaddr = '0;

    always #2 clk = ~clk;

    exc_frame_builder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_fs(req_fs), .req_sr(req_sr), .req_use_next(req_use_next),
        .req_fault_pc(req_fault_pc), .req_next_pc(req_next_pc), .ssp_in(ssp_in),
        .vbr(vbr), .handler_retire(handler_retire), .busy(busy),
        .mem_wvalid(mem_wvalid), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_wready(mem_wready), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .ssp_out(ssp_out), .irq_inhibit(irq_inhibit)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural model advanced on the rising edge from the same inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_base = '0; m_pc = '0; m_fv = '0;
            m_vaddr = '0; m_ssp = '0; m_inh = 1'b0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    logic [3:0] fsx;
                    fsx = (req_vector == 8'd2 || req_vector == 8'd3) ? req_fs : 4'd0;
                    m_base  = ssp_in & ~32'd3;
                    m_pc    = (req_use_next || (req_vector >= 8'd32 && req_vector <= 8'd47))
                              ? req_next_pc : req_fault_pc;
                    m_fv    = {4'(4 + ssp_in[1:0]), fsx[3:2], req_vector, fsx[1:0], req_sr};
                    m_vaddr = vbr + 32'(req_vector) * 4;
                    m_inh   = 1'b1;
                    m_phase = 1;
                end else if (handler_retire) m_inh = 1'b0;
                1: if (mem_wready) begin last_pc = mem_wdata; m_phase = 2; end
                2: if (mem_wready) begin
                    last_fv = mem_wdata; m_ssp = m_base - 32'd8; m_phase = 3;
                end
                default: m_phase = 0;
            endcase
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == (m_phase != 0), "R10 busy", 32'(busy), 32'(m_phase != 0));
            check(mem_wvalid == (m_phase == 1 || m_phase == 2), "R3 wvalid",
                  32'(mem_wvalid), 32'(m_phase == 1 || m_phase == 2));
            if (m_phase == 1) begin
                check(mem_waddr == m_base - 32'd4, "R3 pc addr", mem_waddr, m_base - 32'd4);
                check(mem_wdata == m_pc, "R3 pc data", mem_wdata, m_pc);
            end
            if (m_phase == 2) begin
                check(mem_waddr == m_base - 32'd8, "R4 fv addr", mem_waddr, m_base - 32'd8);
                check(mem_wdata == m_fv, "R4 fv data", mem_wdata, m_fv);
            end
            check(vec_valid == (m_phase == 3), "R8 strobe", 32'(vec_valid), 32'(m_phase == 3));
            if (m_phase == 3)
                check(vec_addr == m_vaddr, "R8 vec addr", vec_addr, m_vaddr);
            check(ssp_out == m_ssp, "R9 ssp", ssp_out, m_ssp);
            check(irq_inhibit == m_inh, "R11 inhibit", 32'(irq_inhibit), 32'(m_inh));
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_wready = wait_mode ? lfsr[0] : 1'b1;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic run_exc(input logic [7:0] vec, input logic [3:0] fs,
                           input logic [15:0] sr, input bit nxt, input logic [31:0] ssp,
                           input bit spam, input bit retire_mid);
        logic [3:0] exp_fs;
        logic [31:0] exp_pc;
        @(negedge clk);
        req_vector = vec; req_fs = fs; req_sr = sr; req_use_next = nxt;
        req_fault_pc = 32'h0001_0000 + 32'(vec); req_next_pc = 32'h0002_0000 + 32'(vec);
        ssp_in = ssp; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!vec_valid) begin
            if (spam) begin
                req_valid = 1'b1; req_vector = 8'd99; req_fs = 4'hF; ssp_in = 32'hDEAD_BEE3;
            end
            handler_retire = retire_mid;
            @(negedge clk);
        end
        last_vaddr = vec_addr;
        req_valid = 1'b0; handler_retire = 1'b0;
        @(negedge clk);
        exp_fs = (vec == 8'd2 || vec == 8'd3) ? fs : 4'd0;
        exp_pc = (nxt || (vec >= 8'd32 && vec <= 8'd47)) ? 32'h0002_0000 + 32'(vec)
                                                        : 32'h0001_0000 + 32'(vec);
        check(busy == 1'b0, "R2/R10 idle after frame", 32'(busy), 32'd0);
        check(last_fv[31:28] == 4'(4 + ssp[1:0]), "R5 format", 32'(last_fv[31:28]),
              32'(4 + ssp[1:0]));
        check({last_fv[27:26], last_fv[17:16]} == exp_fs, "R6 fault status",
              32'({last_fv[27:26], last_fv[17:16]}), 32'(exp_fs));
        check(last_fv[25:18] == vec && last_fv[15:0] == sr, "R4 vector/sr",
              last_fv, {8'd0, vec, sr});
        check(last_pc == exp_pc, "R7 return address", last_pc, exp_pc);
        check(last_vaddr == vbr + 32'(vec) * 4, "R8 table address", last_vaddr,
              vbr + 32'(vec) * 4);
        check(ssp_out == (ssp & ~32'd3) - 32'd8, "R9 new ssp", ssp_out,
              (ssp & ~32'd3) - 32'd8);
        check(irq_inhibit == 1'b1, "R11 inhibit held", 32'(irq_inhibit), 32'd1);
    endtask

    initial begin
        vbr = 32'h0000_4000;
        repeat (3) @(negedge clk);
        check(!busy && !mem_wvalid && !vec_valid && !irq_inhibit && ssp_out == 0,
              "R1 reset state", {busy, mem_wvalid, vec_valid, irq_inhibit}, 32'd0);
        rst_n = 1'b1;
        run_exc(8'd2,   4'hA, 16'h2700, 1'b0, 32'h0000_1000, 1'b0, 1'b0);
        run_exc(8'd3,   4'h5, 16'h2004, 1'b0, 32'h0000_2001, 1'b0, 1'b0);
        run_exc(8'd4,   4'hF, 16'h2010, 1'b0, 32'h0000_3002, 1'b0, 1'b0);
        wait_mode = 1;
        run_exc(8'd35,  4'h3, 16'h0001, 1'b0, 32'h0000_4003, 1'b0, 1'b0);
        run_exc(8'd47,  4'h0, 16'hFFFF, 1'b0, 32'h0000_5000, 1'b1, 1'b1);
        run_exc(8'd48,  4'h0, 16'h1234, 1'b0, 32'h0000_6001, 1'b1, 1'b0);
        vbr = 32'hFFFF_FF00;
        run_exc(8'd255, 4'h2, 16'h5A5A, 1'b1, 32'h0000_7002, 1'b0, 1'b1);
        run_exc(8'd64,  4'h9, 16'hA5A5, 1'b1, 32'h0000_8003, 1'b0, 1'b0);
        wait_mode = 0;
        run_exc(8'd0,   4'h1, 16'h0000, 1'b0, 32'h0000_0003, 1'b0, 1'b0);
        // R11: idle retire drops the inhibit one cycle later
        handler_retire = 1'b1;
        @(negedge clk);
        handler_retire = 1'b0;
        check(irq_inhibit == 1'b0, "R11 idle retire", 32'(irq_inhibit), 32'd0);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule